// File: doc/BRIEF.md
# DRAM Bank Command Timing Guard

This block stands beside the command arbiter of a DRAM controller whose logic runs at half the DRAM clock rate. The arbiter presents one candidate command at a time: its type (activate, read, write or precharge), its bank group and its bank within that group. The guard raises `cand_allowed` only when the minimum spacings that apply to that command have run out. When the arbiter actually sends the command it pulses `issue` with the same candidate fields. The guard then starts the spacing counters that this command opens, at the next clock edge. The block never picks commands; it only gates them.

Four spacings are held in one 32-bit timing register, all counted in controller clocks. Each controller clock is two DRAM clocks:
- activate to read or write on the same bank;
- read to read and write to write;
- activate to activate;
- precharge to activate on the same bank.

Software converts the DRAM-clock requirement to controller clocks. For most fields it halves the value and rounds up. The precharge field uses floor(ceil(tRP/tCK)/2)+1, except for LPDDR4 parts, which use ceil(ceil(tRP/tCK)/2).

In DDR4 mode the column spacing and the activate spacing are tracked separately for each bank group. In other modes they are global. The register accepts writes only while the controller is in a low-power state, or when the frequency-mode logic grants permission.

Top module: `dram_cmd_timing_guard`

## Requirements
- R1: After reset the register reads 0x05040405, and every command type to every bank is allowed immediately.
- R2: A register write takes effect when `pwr_state` is self-refresh (1), deep power-down (2) or maximum power saving (3), or when `freq_wr_permit` is 1. With `pwr_state` normal (0) and `freq_wr_permit` 0, a write leaves the readback unchanged.
- R3: Only these bits hold data, and every other bit reads as zero:
  - activate-to-column field at bits 28:24;
  - column-to-column field at bits 19:16;
  - activate-to-activate field at bits 11:8;
  - precharge-to-activate field at bits 4:0.
- R4: After an activate is issued to a bank, a read or write to that same bank is blocked until the activate-to-column value N has elapsed. The command becomes allowed exactly N clock edges after the issue edge. Other banks are unaffected. Command codes are activate 0, read 1, write 2, precharge 3.
- R5: After a precharge is issued to a bank, an activate to that same bank becomes allowed exactly N edges later, where N is the precharge-to-activate field. An activate to another bank is not delayed by that precharge.
- R6: A read after a read becomes allowed exactly N edges later, where N is the column-to-column field. The same holds for a write after a write. A write after a read is not delayed by this spacing.
- R7: With `ddr4_mode` 1, an activate after an activate in the same bank group waits N edges, where N is the activate-to-activate field. An activate in a different bank group is not delayed.
- R8: With `ddr4_mode` 0, the column-to-column and activate-to-activate spacings apply across all bank groups.
- R9: A field programmed to 0 or 1 imposes no wait: the follow-on command is allowed on the first edge after the issue.
- R10: A precharge candidate is always allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ddr4_mode | input | 1 | 1: column and activate spacing tracked per bank group |
| pwr_state | input | 2 | 0 normal, 1 self-refresh, 2 deep power-down, 3 max power saving |
| freq_wr_permit | input | 1 | Frequency-mode grant that allows register writes |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_data | output | 32 | Register readback |
| cand_cmd | input | 2 | Candidate command type |
| cand_bg | input | $clog2(NUM_BG) | Candidate bank group |
| cand_bank | input | $clog2(BANKS_PER_BG) | Candidate bank within its group |
| issue | input | 1 | The candidate is being sent this cycle |
| cand_allowed | output | 1 | The candidate meets every spacing |

## Verification
The bench builds the guard with four bank groups of four banks each, with per-group tracking enabled. This lets two-command sequences reach the following cases:
- same bank versus a neighbouring bank;
- same group versus another group;
- per-group mode versus global mode.

The main timing values are programmed as four distinct numbers (6, 3, 2 and 7). As a result, a wait measured against the wrong field, or shifted by one edge, shows up as a wrong count. A second programming with zero and one values reaches the no-wait floor.

// File: rtl/dctg_pkg.sv
package dctg_pkg;

   typedef enum logic [1:0] {
      CMD_ACT = 2'd0,
      CMD_RD  = 2'd1,
      CMD_WR  = 2'd2,
      CMD_PRE = 2'd3
   } dctg_cmd_e;

   typedef enum logic [1:0] {
      PWR_NORMAL   = 2'd0,
      PWR_SELF_REF = 2'd1,
      PWR_DEEP_PD  = 2'd2,
      PWR_MAX_SAVE = 2'd3
   } dctg_pwr_e;

   localparam int CFG_W   = 32;
   localparam int RCD_LSB = 24;
   localparam int RCD_W   = 5;
   localparam int CCD_LSB = 16;
   localparam int CCD_W   = 4;
   localparam int RRD_LSB = 8;
   localparam int RRD_W   = 4;
   localparam int RP_LSB  = 0;
   localparam int RP_W    = 5;

   localparam logic [CFG_W-1:0] CFG_RESET = 32'h0504_0405;
   localparam logic [CFG_W-1:0] CFG_MASK  =
      (((32'h1 << RCD_W) - 1) << RCD_LSB) |
      (((32'h1 << CCD_W) - 1) << CCD_LSB) |
      (((32'h1 << RRD_W) - 1) << RRD_LSB) |
      (((32'h1 << RP_W)  - 1) << RP_LSB);

   typedef struct packed {
      logic [RCD_W-1:0] act_to_col;
      logic [CCD_W-1:0] col_to_col;
      logic [RRD_W-1:0] act_to_act;
      logic [RP_W-1:0]  pre_to_act;
   } dctg_timing_t;

endpackage

// File: rtl/dctg_down_ctr.sv
module dctg_down_ctr #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         is_zero
);

   generate
      if (W < 1) begin : g_bad_w
         $error("dctg_down_ctr: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign is_zero = (cnt_q == '0);

   // R1: an idle counter stays expired until something loads it
   p_idle_stays_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (is_zero && !load) |=> is_zero);

   // R4: a nonzero load always opens a blocking window
   p_load_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !is_zero);

endmodule

// File: rtl/dctg_cfg_reg.sv
module dctg_cfg_reg
   import dctg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       pwr_state,
   input  logic             freq_wr_permit,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] rd_data,
   output dctg_timing_t     timing
);

   logic [CFG_W-1:0] cfg_q;
   logic             wr_ok;

   always_comb begin
      wr_ok = freq_wr_permit || (dctg_pwr_e'(pwr_state) != PWR_NORMAL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= CFG_RESET;
      else if (wr_en && wr_ok)
         cfg_q <= wr_data & CFG_MASK;
   end

   assign rd_data           = cfg_q;
   assign timing.act_to_col = cfg_q[RCD_LSB +: RCD_W];
   assign timing.col_to_col = cfg_q[CCD_LSB +: CCD_W];
   assign timing.act_to_act = cfg_q[RRD_LSB +: RRD_W];
   assign timing.pre_to_act = cfg_q[RP_LSB  +: RP_W];

   // R2: a write in normal state without the frequency grant changes nothing
   p_blocked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !freq_wr_permit && pwr_state == 2'd0) |=> $stable(rd_data));

   // R3: reserved bits never hold a one
   p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~CFG_MASK) == '0);

endmodule

// File: rtl/dram_cmd_timing_guard.sv
module dram_cmd_timing_guard
   import dctg_pkg::*;
#(
   parameter int NUM_BG       = 4,
   parameter int BANKS_PER_BG = 4,
   parameter bit BG_TRACKING  = 1'b1,
   localparam int BGW  = $clog2(NUM_BG),
   localparam int BKW  = $clog2(BANKS_PER_BG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ddr4_mode,
   input  logic [1:0]       pwr_state,
   input  logic             freq_wr_permit,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wr_data,
   output logic [CFG_W-1:0] cfg_rd_data,
   input  logic [1:0]       cand_cmd,
   input  logic [BGW-1:0]   cand_bg,
   input  logic [BKW-1:0]   cand_bank,
   input  logic             issue,
   output logic             cand_allowed
);

   localparam int NB   = NUM_BG * BANKS_PER_BG;
   localparam int IDXW = BGW + BKW;
   localparam int NTRK = BG_TRACKING ? NUM_BG : 1;

   generate
      if (NUM_BG < 2 || (NUM_BG & (NUM_BG - 1)) != 0) begin : g_bad_bg
         $error("NUM_BG must be a power of two of at least 2");
      end
      if (BANKS_PER_BG < 2 || (BANKS_PER_BG & (BANKS_PER_BG - 1)) != 0) begin : g_bad_bk
         $error("BANKS_PER_BG must be a power of two of at least 2");
      end
   endgenerate

   dctg_timing_t    tm;
   dctg_cmd_e       cmd;
   logic [IDXW-1:0] bank_idx;
   logic            iss_act, iss_rd, iss_wr, iss_pre;
   logic [RCD_W-1:0] rcd_ld;
   logic [CCD_W-1:0] ccd_ld;
   logic [RRD_W-1:0] rrd_ld;
   logic [RP_W-1:0]  rp_ld;

   logic [NB-1:0]   rcd_zero, rp_zero;
   logic [NTRK-1:0] trk_sel, rd_zero, wr_zero, act_zero;
   logic            grp_rd_ok, grp_wr_ok, grp_act_ok;

   dctg_cfg_reg u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .pwr_state      (pwr_state),
      .freq_wr_permit (freq_wr_permit),
      .wr_en          (cfg_wr_en),
      .wr_data        (cfg_wr_data),
      .rd_data        (cfg_rd_data),
      .timing         (tm)
   );

   always_comb begin
      cmd      = dctg_cmd_e'(cand_cmd);
      bank_idx = {cand_bg, cand_bank};
      iss_act  = issue && (cmd == CMD_ACT);
      iss_rd   = issue && (cmd == CMD_RD);
      iss_wr   = issue && (cmd == CMD_WR);
      iss_pre  = issue && (cmd == CMD_PRE);
      // a spacing of N edges is a counter preload of N-1
      rcd_ld   = (tm.act_to_col == '0) ? '0 : tm.act_to_col - RCD_W'(1);
      ccd_ld   = (tm.col_to_col == '0) ? '0 : tm.col_to_col - CCD_W'(1);
      rrd_ld   = (tm.act_to_act == '0) ? '0 : tm.act_to_act - RRD_W'(1);
      rp_ld    = (tm.pre_to_act == '0) ? '0 : tm.pre_to_act - RP_W'(1);
   end

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         dctg_down_ctr #(.W(RCD_W)) u_act_col (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (iss_act && (bank_idx == IDXW'(b))),
            .load_val (rcd_ld),
            .is_zero  (rcd_zero[b])
         );
         dctg_down_ctr #(.W(RP_W)) u_pre_act (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (iss_pre && (bank_idx == IDXW'(b))),
            .load_val (rp_ld),
            .is_zero  (rp_zero[b])
         );
      end

      for (genvar g = 0; g < NTRK; g++) begin : g_trk
         dctg_down_ctr #(.W(CCD_W)) u_rd_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (iss_rd && trk_sel[g]),
            .load_val (ccd_ld),
            .is_zero  (rd_zero[g])
         );
         dctg_down_ctr #(.W(CCD_W)) u_wr_wr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (iss_wr && trk_sel[g]),
            .load_val (ccd_ld),
            .is_zero  (wr_zero[g])
         );
         dctg_down_ctr #(.W(RRD_W)) u_act_act (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (iss_act && trk_sel[g]),
            .load_val (rrd_ld),
            .is_zero  (act_zero[g])
         );
      end

      if (BG_TRACKING) begin : g_per_group
         // outside per-group mode every tracker loads together, so any one is global
         for (genvar g = 0; g < NTRK; g++) begin : g_sel
            assign trk_sel[g] = !ddr4_mode || (cand_bg == BGW'(g));
         end
         assign grp_rd_ok  = rd_zero[cand_bg];
         assign grp_wr_ok  = wr_zero[cand_bg];
         assign grp_act_ok = act_zero[cand_bg];
      end else begin : g_single
         logic unused_mode;
         assign unused_mode = ddr4_mode;
         assign trk_sel     = 1'b1;
         assign grp_rd_ok   = rd_zero[0];
         assign grp_wr_ok   = wr_zero[0];
         assign grp_act_ok  = act_zero[0];
      end
   endgenerate

   always_comb begin
      unique case (cmd)
         CMD_ACT: cand_allowed = rp_zero[bank_idx]  && grp_act_ok;
         CMD_RD:  cand_allowed = rcd_zero[bank_idx] && grp_rd_ok;
         CMD_WR:  cand_allowed = rcd_zero[bank_idx] && grp_wr_ok;
         default: cand_allowed = 1'b1;
      endcase
   end

   // R10: precharge is never held back
   p_pre_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_cmd == 2'd3) |-> cand_allowed);

   // R4: the bank just activated is not open for columns on the next cycle
   p_act_blocks_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cand_cmd == 2'd0 && tm.act_to_col > RCD_W'(1))
      |=> !rcd_zero[$past(bank_idx)]);

   // R5: the bank just precharged is not open for activate on the next cycle
   p_pre_blocks_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cand_cmd == 2'd3 && tm.pre_to_act > RP_W'(1))
      |=> !rp_zero[$past(bank_idx)]);

endmodule

// File: tb/tb_dram_cmd_timing_guard.sv
module tb_dram_cmd_timing_guard;

   localparam int NUM_BG = 4;
   localparam int BPG    = 4;
   localparam int T_RCD  = 6;
   localparam int T_CCD  = 3;
   localparam int T_RRD  = 2;
   localparam int T_RP   = 7;
   localparam logic [31:0] MAIN_CFG = {3'b0, 5'(T_RCD), 4'b0, 4'(T_CCD),
                                       4'b0, 4'(T_RRD), 3'b0, 5'(T_RP)};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ddr4_mode = 1'b1;
   logic [1:0]  pwr_state = 2'd0;
   logic        freq_wr_permit = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic [31:0] cfg_rd_data;
   logic [1:0]  cand_cmd = 2'd3;
   logic [1:0]  cand_bg = '0;
   logic [1:0]  cand_bank = '0;
   logic        issue = 1'b0;
   logic        cand_allowed;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dram_cmd_timing_guard #(.NUM_BG(NUM_BG), .BANKS_PER_BG(BPG), .BG_TRACKING(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ddr4_mode(ddr4_mode), .pwr_state(pwr_state),
      .freq_wr_permit(freq_wr_permit), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(cfg_rd_data), .cand_cmd(cand_cmd), .cand_bg(cand_bg),
      .cand_bank(cand_bank), .issue(issue), .cand_allowed(cand_allowed)
   );

   typedef struct packed {
      logic       ddr4;
      logic [1:0] c1, g1, b1;
      logic [1:0] c2, g2, b2;
      logic [7:0] exp_wait;
      logic [7:0] req;
   } vec_t;

   // commands: 0 activate, 1 read, 2 write, 3 precharge
   localparam vec_t VT [13] = '{
      '{1'b1, 2'd0,2'd0,2'd0, 2'd1,2'd0,2'd0, 8'(T_RCD), 8'd4},  // R4 act->rd same bank
      '{1'b1, 2'd0,2'd0,2'd0, 2'd2,2'd0,2'd0, 8'(T_RCD), 8'd4},  // R4 act->wr same bank
      '{1'b1, 2'd0,2'd0,2'd0, 2'd1,2'd1,2'd2, 8'd1,      8'd4},  // R4 other bank free
      '{1'b1, 2'd3,2'd1,2'd1, 2'd0,2'd1,2'd1, 8'(T_RP),  8'd5},  // R5 pre->act same bank
      '{1'b1, 2'd3,2'd1,2'd1, 2'd0,2'd1,2'd2, 8'd1,      8'd5},  // R5 other bank free
      '{1'b1, 2'd1,2'd2,2'd0, 2'd1,2'd2,2'd3, 8'(T_CCD), 8'd6},  // R6 rd->rd
      '{1'b1, 2'd1,2'd2,2'd0, 2'd2,2'd2,2'd0, 8'd1,      8'd6},  // R6 rd->wr free
      '{1'b1, 2'd0,2'd3,2'd0, 2'd0,2'd3,2'd1, 8'(T_RRD), 8'd7},  // R7 same group
      '{1'b1, 2'd0,2'd3,2'd0, 2'd0,2'd0,2'd1, 8'd1,      8'd7},  // R7 other group
      '{1'b0, 2'd1,2'd0,2'd0, 2'd1,2'd3,2'd0, 8'(T_CCD), 8'd8},  // R8 global rd
      '{1'b0, 2'd0,2'd0,2'd0, 2'd0,2'd2,2'd0, 8'(T_RRD), 8'd8},  // R8 global act
      '{1'b0, 2'd2,2'd1,2'd0, 2'd2,2'd2,2'd0, 8'(T_CCD), 8'd8},  // R8 global wr
      '{1'b1, 2'd0,2'd0,2'd0, 2'd3,2'd0,2'd0, 8'd1,      8'd10} // R10 pre right after act
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] pw, input logic perm, input logic [31:0] d);
      @(negedge clk);
      pwr_state = pw; freq_wr_permit = perm; cfg_wr_en = 1'b1; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0; pwr_state = 2'd0; freq_wr_permit = 1'b0;
      #1;
   endtask

   // issue the first command, then count edges until the second is allowed
   task automatic measure(input logic d4, input logic [1:0] c1, g1, b1,
                          input logic [1:0] c2, g2, b2, output int waited);
      @(negedge clk);
      ddr4_mode = d4; cand_cmd = c1; cand_bg = g1; cand_bank = b1; issue = 1'b1;
      @(negedge clk);
      issue = 1'b0; cand_cmd = c2; cand_bg = g2; cand_bank = b2;
      #1;
      waited = 1;
      while (!cand_allowed && waited < 64) begin
         @(negedge clk); #1;
         waited++;
      end
      cand_cmd = 2'd3;
      repeat (40) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset value and everything open
      check(cfg_rd_data == 32'h0504_0405, "R1 reset value", cfg_rd_data, 32'h0504_0405);
      for (int c = 0; c < 4; c++) begin
         cand_cmd = 2'(c); cand_bg = 2'(c); cand_bank = 2'(3 - c); #1;
         check(cand_allowed, "R1 open after reset", cand_allowed, 1);
      end
      cand_cmd = 2'd3;

      // R2: write gating by power state
      cfg_write(2'd0, 1'b0, 32'h0A0B_0C0D);
      check(cfg_rd_data == 32'h0504_0405, "R2 normal write ignored", cfg_rd_data, 32'h0504_0405);
      cfg_write(2'd1, 1'b0, 32'h0102_0304);
      check(cfg_rd_data == 32'h0102_0304, "R2 self-refresh write", cfg_rd_data, 32'h0102_0304);
      cfg_write(2'd0, 1'b1, 32'h0203_0405);
      check(cfg_rd_data == 32'h0203_0405, "R2 freq grant write", cfg_rd_data, 32'h0203_0405);
      cfg_write(2'd2, 1'b0, 32'h0304_0506);
      check(cfg_rd_data == 32'h0304_0506, "R2 deep power-down write", cfg_rd_data, 32'h0304_0506);
      cfg_write(2'd3, 1'b0, 32'hFFFF_FFFF);
      // R3: reserved bits read zero
      check(cfg_rd_data == 32'h1F0F_0F1F, "R3 reserved bits", cfg_rd_data, 32'h1F0F_0F1F);

      cfg_write(2'd1, 1'b0, MAIN_CFG);
      check(cfg_rd_data == MAIN_CFG, "R2 main config", cfg_rd_data, MAIN_CFG);

      foreach (VT[i]) begin
         measure(VT[i].ddr4, VT[i].c1, VT[i].g1, VT[i].b1,
                 VT[i].c2, VT[i].g2, VT[i].b2, w);
         check(w == int'(VT[i].exp_wait), $sformatf("R%0d vector %0d", VT[i].req, i),
               w, VT[i].exp_wait);
      end

      // R9: fields of 0 and 1 give no wait
      cfg_write(2'd2, 1'b0, 32'h0100_0000);
      measure(1'b1, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, w);
      check(w == 1, "R9 act->rd field 1", w, 1);
      measure(1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, w);
      check(w == 1, "R9 rd->rd field 0", w, 1);
      measure(1'b1, 2'd0, 2'd2, 2'd0, 2'd0, 2'd2, 2'd1, w);
      check(w == 1, "R9 act->act field 0", w, 1);
      measure(1'b1, 2'd3, 2'd2, 2'd0, 2'd0, 2'd2, 2'd0, w);
      check(w == 1, "R9 pre->act field 0", w, 1);

      // R10: precharge allowed even while its bank is mid-window
      cfg_write(2'd3, 1'b0, MAIN_CFG);
      @(negedge clk);
      cand_cmd = 2'd0; cand_bg = 2'd3; cand_bank = 2'd3; issue = 1'b1;
      @(negedge clk);
      issue = 1'b0; cand_cmd = 2'd3; #1;
      check(cand_allowed, "R10 pre during window", cand_allowed, 1);
      cand_cmd = 2'd1; #1;
      check(!cand_allowed, "R4 rd blocked in window", cand_allowed, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule